// File: doc/BRIEF.md
# Fractional-Delay Multipath Component Generator

This block forms one delayed, scaled and faded copy of a complex baseband sample stream. This is the per-path building block of a multipath channel emulator. The requested delay is K + μ sample periods. K is an integer from 0 to 63 and μ is an 8-bit fraction. The integer part picks taps from a shift-register delay line. The fractional part is filled in by a cubic polynomial interpolator. Its four fixed branch filters are combined in Horner form with μ as the variable.

The interpolated sample is multiplied by a real path amplitude. It is then multiplied by a complex fading sample. Each new input sample is qualified by a valid strobe. The delay, fraction, amplitude and fading value that apply to a sample are the ones present in the cycle that sample is accepted. Summing several paths and producing the fading process are left to neighbouring blocks.

Top module: `frac_delay_path`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0. While reset is asserted, out_i and out_q are 0.
- R2: out_valid is 1 in exactly the cycle four clock cycles after each cycle in which in_valid is 1, and 0 in every other cycle. The order of the outputs follows the order of the inputs.
- R3: Let x[0] be the sample just accepted and x[j] the sample accepted j samples earlier. Let s0..s3 be x[K]..x[K+3] for each of I and Q, with μ an unsigned integer 0..255 weighted 1/256. The interpolated value is computed as follows. Start with c0=2·s1, c1=s2−s0, c2=2·s0−5·s1+4·s2−s3 and c3=s3−s0+3·(s1−s2). Set h=c3. Three times, in the order c2, c1, c0, set h = c + floor(h·μ/256). The result is floor(h/2). This is a delay of K+1+μ/256 samples.
- R4: With μ=0 the interpolated value equals x[K+1] exactly, for every K from 0 to 63.
- R5: The interpolated value is saturated to the range −32768..32767.
- R6: The amplitude stage multiplies each interpolated component by cfg_alpha, a signed value weighted 2^-15. The product is rounded by adding 2^14 and arithmetically shifting right by 15, then saturated to 16 bits.
- R7: The fading stage forms re = a_i·f_i − a_q·f_q and im = a_i·f_q + a_q·f_i, where fade_i and fade_q are signed values weighted 2^-15. Each result is rounded and saturated as in R6, and driven on out_i and out_q.
- R8: cfg_k, cfg_mu, cfg_alpha, fade_i and fade_q are taken only in cycles with in_valid at 1. Values present in other cycles do not change any output.
- R9: The delay line advances by one position only on an accepted sample. Idle cycles do not move history.
- R10: After reset the history reads as zero, so taps reaching before the first accepted sample contribute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept in_i/in_q and the configuration this cycle |
| in_i | input | 16 | Input sample, in-phase, signed |
| in_q | input | 16 | Input sample, quadrature, signed |
| cfg_k | input | 6 | Integer delay K in samples |
| cfg_mu | input | 8 | Fractional delay μ, units of 1/256 sample |
| cfg_alpha | input | 16 | Path amplitude, signed, weight 2^-15 |
| fade_i | input | 16 | Fading sample real part, signed, weight 2^-15 |
| fade_q | input | 16 | Fading sample imaginary part, signed, weight 2^-15 |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Path output, in-phase, signed |
| out_q | output | 16 | Path output, quadrature, signed |

## Verification
The bench drives K at both ends of its range, including K=63 before the line has filled. A design that read uninitialised history, or indexed one tap off, returns non-zero values or samples shifted by one.

Overshoot patterns push the cubic past full scale. An interpolator without saturation would wrap to the opposite sign. The fading stage is driven at its corners, with both factors at −1 and a full-scale sum. A missing clamp there flips the sign of the output.

Configuration and data are scrambled in idle cycles, and the gaps between samples vary. A design that sampled its settings, or shifted its line, outside accepted cycles produces outputs at the wrong delay or gain. The arrival cycle of every output is compared with the cycle its input was accepted. An extra or missing pipeline register therefore shows up directly.

// File: rtl/fdpath_pkg.sv
package fdpath_pkg;

  parameter int SAMP_W  = 16;
  parameter int MU_W    = 8;
  parameter int ACC_W   = SAMP_W + 8;
  parameter int PROD_W  = 2 * SAMP_W + 2;
  parameter int FRAC_SH = SAMP_W - 1;
  parameter int NTAP    = 4;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  typedef struct packed {
    samp_t re;
    samp_t im;
  } cplx_t;

  localparam prod_t MAXV = prod_t'((64'sd1 <<< (SAMP_W - 1)) - 64'sd1);
  localparam prod_t MINV = -MAXV - prod_t'(1);
  localparam prod_t HALF = prod_t'(64'sd1 <<< (FRAC_SH - 1));

  // Clamp a wide value into the sample range (R5, R6, R7)
  function automatic samp_t sat_w(prod_t v);
    if (v > MAXV)      return samp_t'({1'b0, {(SAMP_W-1){1'b1}}});
    else if (v < MINV) return samp_t'({1'b1, {(SAMP_W-1){1'b0}}});
    else               return samp_t'(v[SAMP_W-1:0]);
  endfunction

  // Round half up at bit FRAC_SH, then clamp (R6, R7)
  function automatic samp_t round_q(prod_t v);
    return sat_w((v + HALF) >>> FRAC_SH);
  endfunction

  function automatic prod_t mul_w(samp_t a, samp_t b);
    return prod_t'(a) * prod_t'(b);
  endfunction

  // Cubic branch filters combined in Horner form on mu (R3, R4)
  function automatic samp_t farrow_eval(samp_t s0, samp_t s1, samp_t s2,
                                        samp_t s3, logic [MU_W-1:0] mu);
    acc_t e0, e1, e2, e3;
    acc_t c0, c1, c2, c3, h;
    logic signed [ACC_W+MU_W:0] p;
    e0 = acc_t'(s0);
    e1 = acc_t'(s1);
    e2 = acc_t'(s2);
    e3 = acc_t'(s3);
    c0 = e1 <<< 1;
    c1 = e2 - e0;
    c2 = (e0 <<< 1) - ((e1 <<< 2) + e1) + (e2 <<< 2) - e3;
    c3 = e3 - e0 + ((e1 - e2) <<< 1) + (e1 - e2);
    h  = c3;
    p  = h * $signed({1'b0, mu});
    h  = c2 + acc_t'(p >>> MU_W);
    p  = h * $signed({1'b0, mu});
    h  = c1 + acc_t'(p >>> MU_W);
    p  = h * $signed({1'b0, mu});
    h  = c0 + acc_t'(p >>> MU_W);
    return sat_w(prod_t'(h >>> 1));
  endfunction

endpackage

// File: rtl/fdp_delay_line.sv
module fdp_delay_line
  import fdpath_pkg::*;
#(
  parameter int K_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  cplx_t               din,
  input  logic [K_W-1:0]      k,
  output cplx_t [NTAP-1:0]    taps
);
  localparam int LEN   = (1 << K_W) + NTAP - 1;
  localparam int IDX_W = $clog2(LEN);

  cplx_t line [LEN];

  // History clears on reset (R10) and moves only on accepted samples (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN; i++) line[i] <= '0;
    end else if (shift_en) begin
      line[0] <= din;
      for (int i = 1; i < LEN; i++) line[i] <= line[i-1];
    end
  end

  for (genvar j = 0; j < NTAP; j++) begin : g_tap
    assign taps[j] = line[IDX_W'(k) + IDX_W'(j)];
  end

endmodule

// File: rtl/fdp_farrow.sv
module fdp_farrow
  import fdpath_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cplx_t [NTAP-1:0] taps,
  input  logic [MU_W-1:0]  mu,
  output cplx_t            y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y <= '0;
    end else if (en) begin
      y.re <= farrow_eval(taps[0].re, taps[1].re, taps[2].re, taps[3].re, mu);
      y.im <= farrow_eval(taps[0].im, taps[1].im, taps[2].im, taps[3].im, mu);
    end
  end
endmodule

// File: rtl/fdp_gain.sv
module fdp_gain
  import fdpath_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  cplx_t x,
  input  samp_t alpha,
  output cplx_t y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y <= '0;
    end else if (en) begin
      y.re <= round_q(mul_w(x.re, alpha));
      y.im <= round_q(mul_w(x.im, alpha));
    end
  end
endmodule

// File: rtl/fdp_cmul.sv
module fdp_cmul
  import fdpath_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  cplx_t a,
  input  cplx_t f,
  output cplx_t y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y <= '0;
    end else if (en) begin
      y.re <= round_q(mul_w(a.re, f.re) - mul_w(a.im, f.im));
      y.im <= round_q(mul_w(a.re, f.im) + mul_w(a.im, f.re));
    end
  end
endmodule

// File: rtl/frac_delay_path.sv
module frac_delay_path
  import fdpath_pkg::*;
#(
  parameter int K_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic signed [SAMP_W-1:0] in_i,
  input  logic signed [SAMP_W-1:0] in_q,
  input  logic [K_W-1:0]    cfg_k,
  input  logic [MU_W-1:0]   cfg_mu,
  input  logic signed [SAMP_W-1:0] cfg_alpha,
  input  logic signed [SAMP_W-1:0] fade_i,
  input  logic signed [SAMP_W-1:0] fade_q,
  output logic              out_valid,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q
);
  logic             stg1_v, stg2_v, stg3_v;
  logic [K_W-1:0]   k_q;
  logic [MU_W-1:0]  mu_q;
  samp_t            alpha_q1, alpha_q2;
  cplx_t            fade_q1, fade_q2, fade_q3;
  cplx_t            din;
  cplx_t [NTAP-1:0] taps;
  cplx_t            frac, gain, res;

  // Named internal events for the checker
  samp_t tap1_re, frac_re, gain_re, gain_im;
  assign tap1_re = taps[1].re;
  assign frac_re = frac.re;
  assign gain_re = gain.re;
  assign gain_im = gain.im;

  assign din = '{re: in_i, im: in_q};

  // Stage valids and settings captured with each accepted sample (R2, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_v    <= 1'b0;
      stg2_v    <= 1'b0;
      stg3_v    <= 1'b0;
      out_valid <= 1'b0;
      k_q       <= '0;
      mu_q      <= '0;
      alpha_q1  <= '0;
      alpha_q2  <= '0;
      fade_q1   <= '0;
      fade_q2   <= '0;
      fade_q3   <= '0;
    end else begin
      stg1_v    <= in_valid;
      stg2_v    <= stg1_v;
      stg3_v    <= stg2_v;
      out_valid <= stg3_v;
      if (in_valid) begin
        k_q      <= cfg_k;
        mu_q     <= cfg_mu;
        alpha_q1 <= cfg_alpha;
        fade_q1  <= '{re: fade_i, im: fade_q};
      end
      if (stg1_v) begin
        alpha_q2 <= alpha_q1;
        fade_q2  <= fade_q1;
      end
      if (stg2_v) fade_q3 <= fade_q2;
    end
  end

  fdp_delay_line #(.K_W(K_W)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(din), .k(k_q), .taps(taps)
  );

  fdp_farrow u_frac (
    .clk(clk), .rst_n(rst_n), .en(stg1_v), .taps(taps), .mu(mu_q), .y(frac)
  );

  fdp_gain u_gain (
    .clk(clk), .rst_n(rst_n), .en(stg2_v), .x(frac), .alpha(alpha_q2), .y(gain)
  );

  fdp_cmul u_cmul (
    .clk(clk), .rst_n(rst_n), .en(stg3_v), .a(gain), .f(fade_q3), .y(res)
  );

  assign out_i = res.re;
  assign out_q = res.im;

endmodule

// File: rtl/frac_delay_path_chk.sv
module frac_delay_path_chk
  import fdpath_pkg::*;
#(
  parameter int K_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            stg1_v,
  input logic            stg2_v,
  input logic            stg3_v,
  input logic            out_valid,
  input logic [MU_W-1:0] mu_q,
  input samp_t           alpha_q2,
  input samp_t           tap1_re,
  input samp_t           frac_re,
  input samp_t           gain_re,
  input samp_t           gain_im,
  input samp_t           out_i,
  input samp_t           out_q
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> stg1_v);

  p_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stg1_v |=> stg2_v);

  p_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stg3_v |=> out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stg3_v |=> !out_valid);

  p_integer_tap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stg1_v && mu_q == '0) |=> frac_re == $past(tap1_re));

  p_zero_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stg2_v && alpha_q2 == '0) |=> (gain_re == '0 && gain_im == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stg3_v |=> ($stable(out_i) && $stable(out_q)));

endmodule

bind frac_delay_path frac_delay_path_chk #(.K_W(K_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stg1_v(stg1_v),
  .stg2_v(stg2_v), .stg3_v(stg3_v), .out_valid(out_valid), .mu_q(mu_q),
  .alpha_q2(alpha_q2), .tap1_re(tap1_re), .frac_re(frac_re),
  .gain_re(gain_re), .gain_im(gain_im), .out_i(out_i), .out_q(out_q)
);

// File: tb/frac_delay_path_test.sv
`timescale 1ns/1ps
module frac_delay_path_test;
  localparam int HLEN = 67;
  localparam int WD   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0, cfg_alpha = '0, fade_i = '0, fade_q = '0;
  logic [5:0] cfg_k = '0;
  logic [7:0] cfg_mu = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #4 clk = ~clk;

  frac_delay_path uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_k(cfg_k), .cfg_mu(cfg_mu), .cfg_alpha(cfg_alpha), .fade_i(fade_i),
    .fade_q(fade_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  typedef struct {
    int    ei;
    int    eq;
    int    due;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t m_e;
  int   hist_i [HLEN];
  int   hist_q [HLEN];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int b_sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int b_rnd(longint v);
    return b_sat((v + 16384) >>> 15);
  endfunction

  function automatic int b_interp(int p0, int p1, int p2, int p3, int mu);
    longint c [4];
    longint acc;
    c[0] = 2 * p1;
    c[1] = p2 - p0;
    c[2] = 2 * p0 - 5 * p1 + 4 * p2 - p3;
    c[3] = p3 - p0 + 3 * (p1 - p2);
    acc = c[3];
    for (int i = 2; i >= 0; i--) acc = c[i] + ((acc * mu) >>> 8);
    return b_sat(acc >>> 1);
  endfunction

  function automatic int r16();
    return int'($signed(16'($urandom)));
  endfunction

  function automatic int rsmall();
    return int'($urandom_range(0, 16000)) - 8000;
  endfunction

  task automatic scramble();
    in_i = 16'($urandom); in_q = 16'($urandom);
    cfg_k = 6'($urandom); cfg_mu = 8'($urandom);
    cfg_alpha = 16'($urandom);
    fade_i = 16'($urandom); fade_q = 16'($urandom);
  endtask

  // Driver: model the expected result, queue it, then present the sample
  task automatic send(input int xi, input int xq, input int k, input int mu,
                      input int al, input int fi, input int fq,
                      input string tag, input int gap);
    exp_t e;
    int fr_i, fr_q, gi, gq;
    for (int j = HLEN - 1; j > 0; j--) begin
      hist_i[j] = hist_i[j-1];
      hist_q[j] = hist_q[j-1];
    end
    hist_i[0] = xi;
    hist_q[0] = xq;
    fr_i = b_interp(hist_i[k], hist_i[k+1], hist_i[k+2], hist_i[k+3], mu);
    fr_q = b_interp(hist_q[k], hist_q[k+1], hist_q[k+2], hist_q[k+3], mu);
    gi = b_rnd(longint'(fr_i) * al);
    gq = b_rnd(longint'(fr_q) * al);
    e.ei  = b_rnd(longint'(gi) * fi - longint'(gq) * fq);
    e.eq  = b_rnd(longint'(gi) * fq + longint'(gq) * fi);
    e.due = cyc + 4;
    e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1;
    in_i = 16'(xi); in_q = 16'(xq);
    cfg_k = 6'(k); cfg_mu = 8'(mu); cfg_alpha = 16'(al);
    fade_i = 16'(fi); fade_q = 16'(fq);
    @(negedge clk);
    in_valid = 1'b0;
    scramble();
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      scramble();
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R2: out_valid at cycle %0d, actual 1 expected 0", cyc);
      end else begin
        m_e = sb.pop_front();
        if (cyc != m_e.due) begin
          n_bad++;
          $display("FAIL R2: output arrival cycle actual %0d expected %0d", cyc, m_e.due);
        end
        n_chk++;
        if (int'(out_i) != m_e.ei || int'(out_q) != m_e.eq) begin
          n_bad++;
          $display("FAIL %s: actual (%0d,%0d) expected (%0d,%0d)",
                   m_e.tag, out_i, out_q, m_e.ei, m_e.eq);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc >= WD && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R2: watchdog expired, actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < HLEN; j++) begin hist_i[j] = 0; hist_q[j] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
      n_bad++;
      $display("FAIL R1: reset outputs actual %b/%0d/%0d expected 0/0/0", out_valid, out_i, out_q);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out_valid after release actual %b expected 0", out_valid);
    end

    // R10: deepest taps read cleared history
    for (int i = 0; i < 3; i++) send(1000 + i, -500, 63, 0, 32767, 32767, 0, "R10", 1);
    // R4: integer delay at K=0
    for (int i = 0; i < 8; i++) send(100 * i, -37 * i, 0, 0, 32767, 32767, 0, "R4", 0);
    // R4: integer delay at K=63 across and past a full line
    for (int i = 0; i < 70; i++) send(rsmall(), rsmall(), 63, 0, 32767, 32767, 0, "R4", 0);
    // R3: random fractional delays, back to back
    for (int i = 0; i < 150; i++)
      send(r16(), r16(), int'($urandom_range(0, 63)), int'($urandom_range(0, 255)),
           32767, 32767, 0, "R3", 0);
    // R8 R9: scrambled idle cycles between samples, everything random
    for (int i = 0; i < 100; i++)
      send(r16(), r16(), int'($urandom_range(0, 63)), int'($urandom_range(0, 255)),
           r16(), r16(), r16(), "R8 R9", int'($urandom_range(1, 4)));
    // R5: overshoot in both directions
    send(-32768, 32767, 0, 128, 32767, 32767, 0, "R5", 0);
    send(32767, -32768, 0, 128, 32767, 32767, 0, "R5", 0);
    send(32767, -32768, 0, 128, 32767, 32767, 0, "R5", 0);
    send(-32768, 32767, 0, 128, 32767, 32767, 0, "R5", 0);
    send(-32768, 32767, 0, 64, 32767, 32767, 0, "R5", 0);
    send(32767, -32768, 0, 192, 32767, 32767, 0, "R5", 0);
    // R6: amplitude corners
    for (int i = 0; i < 6; i++) send(r16(), r16(), 2, 77, 0, 32767, 0, "R6", 0);
    for (int i = 0; i < 6; i++) send(r16(), r16(), 5, 0, -32768, 32767, 0, "R6", 0);
    for (int i = 0; i < 6; i++) send(r16(), r16(), 1, 200, 12345, 32767, 0, "R6", 1);
    // R7: fading corners
    for (int i = 0; i < 5; i++) send(-32768, -32768, 0, 0, -32768, -32768, -32768, "R7", 0);
    for (int i = 0; i < 5; i++) send(32767, -32767, 0, 0, 32767, 32767, 32767, "R7", 0);
    for (int i = 0; i < 5; i++) send(r16(), r16(), 3, 10, 32767, 0, -32768, "R7", 0);
    for (int i = 0; i < 5; i++) send(r16(), r16(), 7, 99, r16(), r16(), r16(), "R7", 0);

    repeat (12) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: outputs missing, actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule